// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is one channel of a free-running timer. It owns a general register that acts either as a compare value or as a capture latch. A 4-bit mode field picks the function. The timer counter itself is outside the block; its value comes in on `cnt_in`.

In compare mode the channel watches for the counter to equal the general register. Writing the mode sets the pin to a chosen starting level. On each match the pin is then driven low, driven high, toggled, or left alone. The channel also emits a one-cycle match strobe, which a neighbouring channel can use as its event input.

In capture mode the channel loads the counter value into the general register. The trigger is a chosen edge of the synchronised pin input or, on the cross-channel variant, the external event strobe. Every capture raises a one-cycle flag. A software write to the general register wins over a capture that lands in the same cycle.

Top module: `tmr_cc_chan`

## Requirements
- R1: After a synchronous reset, `mode_q` is 0000, `gr_q` is 0, and `pin_out`, `pin_oe`, `cap_flag` and `cmp_evt` are all 0.
- R2: A cycle with `wr_mode` high loads `wdata[3:0]` into `mode_q` on the next edge. Bit 3 selects compare (0) or capture (1). When bit 3 is 0, the same edge sets `pin_out` to bit 2 of the written value.
- R3: In compare mode, a cycle with `cnt_in == gr_q` is a match. Bits 1:0 select the pin action on the next edge: 00 none, 01 drive 0, 10 drive 1, 11 toggle.
- R4: `pin_oe` is 1 only when `mode_q` is in compare mode with bits 1:0 not 00. It changes on the edge that loads the mode, so it is 0 in capture mode.
- R5: In compare mode, `cmp_evt` is high for the one cycle after each match cycle, whatever the pin action.
- R6: `pin_in` passes through two synchronising flops and an edge detector. A pin change that is set up before edge k is captured on edge k+2.
- R7: Capture edge select: mode 1x00 captures on a rising edge, 1x01 on a falling edge, and 1x1x on both edges. With the cross-channel source enabled, these apply only when bit 2 is 0.
- R8: With the cross-channel source enabled, mode 11xx ignores the pin. It captures on the edge after any cycle in which `evt_in` is high.
- R9: A capture loads the `cnt_in` value of the trigger cycle into `gr_q` and sets `cap_flag` for exactly that following cycle.
- R10: If `wr_gr` and a capture trigger fall in the same cycle, `gr_q` takes `wdata` and `cap_flag` stays 0.
- R11: A cycle with `wr_gr` high loads `wdata` into `gr_q` on the next edge, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode | input | 1 | Write strobe for the mode field |
| wr_gr | input | 1 | Write strobe for the general register |
| wdata | input | CNT_W | Write data; the mode write uses bits 3:0 |
| cnt_in | input | CNT_W | Free-running counter value |
| pin_in | input | 1 | Asynchronous capture pin |
| evt_in | input | 1 | Cross-channel event strobe |
| mode_q | output | 4 | Current mode field |
| gr_q | output | CNT_W | General register |
| pin_out | output | 1 | Compare output level |
| pin_oe | output | 1 | Output enable for the pin |
| cmp_evt | output | 1 | One-cycle compare-match strobe |
| cap_flag | output | 1 | One-cycle capture flag |

## Verification
A wrong mode register shows at the ports on the edge that loads it. `pin_oe` and the starting pin level are visible one cycle after the write. The first match then exposes a wrong action decode on the next edge.

A fault in the synchroniser or edge detector shows as a capture one edge early or late, or as a missing capture. It can also show as a capture on the wrong edge, with `gr_q` and `cap_flag` moving three edges after the pin change. A broken write-versus-capture priority shows in the single cycle after the collision.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TGL  = 2'b11
  } cmp_act_e;

  function automatic logic is_capture(input logic [MODE_W-1:0] m);
    return m[3];
  endfunction

  function automatic logic drives_pin(input logic [MODE_W-1:0] m);
    return !m[3] && (m[1:0] != 2'b00);
  endfunction
endpackage

// File: rtl/tmr_cc_insync.sv
module tmr_cc_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES;

  // sh[STAGES-1] is the synchronised sample, sh[STAGES] the previous one
  logic [LAST:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[LAST-1:0], din};
  end

  assign rise = sh[LAST-1] & ~sh[LAST];
  assign fall = ~sh[LAST-1] & sh[LAST];
endmodule

// File: rtl/tmr_cc_trigsel.sv
module tmr_cc_trigsel
  import tmr_cc_pkg::*;
#(
  parameter bit HAS_XSRC = 1'b1
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              rise,
  input  logic              fall,
  input  logic              evt,
  output logic              trig
);
  logic edge_trig;

  always_comb begin
    unique case (mode[1:0])
      2'b00:   edge_trig = rise;
      2'b01:   edge_trig = fall;
      default: edge_trig = rise | fall;
    endcase
  end

  generate
    if (HAS_XSRC) begin : g_xsrc
      assign trig = is_capture(mode) && (mode[2] ? evt : edge_trig);
    end else begin : g_pin_only
      logic unused_evt;
      assign unused_evt = evt;
      assign trig = is_capture(mode) && edge_trig;
    end
  endgenerate
endmodule

// File: rtl/tmr_cc_pinout.sv
module tmr_cc_pinout
  import tmr_cc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_new,
  input  logic [MODE_W-1:0] mode_cur,
  input  logic              match,
  output logic              pin_out,
  output logic              pin_oe
);
  cmp_act_e act;
  assign act = cmp_act_e'(mode_cur[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else if (mode_wr) begin
      pin_oe <= drives_pin(mode_new);
      if (!is_capture(mode_new)) pin_out <= mode_new[2];
    end else if (match && !is_capture(mode_cur)) begin
      unique case (act)
        ACT_LOW:  pin_out <= 1'b0;
        ACT_HIGH: pin_out <= 1'b1;
        ACT_TGL:  pin_out <= ~pin_out;
        default:  pin_out <= pin_out;
      endcase
    end
  end
endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_XSRC    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode,
  input  logic              wr_gr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              pin_in,
  input  logic              evt_in,
  output logic [MODE_W-1:0] mode_q,
  output logic [CNT_W-1:0]  gr_q,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              cmp_evt,
  output logic              cap_flag
);
  logic              rise, fall, trig, match;
  logic [MODE_W-1:0] mode_new;

  assign mode_new = wdata[MODE_W-1:0];
  assign match    = (cnt_in == gr_q);

  tmr_cc_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .rise(rise), .fall(fall)
  );

  tmr_cc_trigsel #(.HAS_XSRC(HAS_XSRC)) u_trig (
    .mode(mode_q), .rise(rise), .fall(fall), .evt(evt_in), .trig(trig)
  );

  tmr_cc_pinout u_pin (
    .clk(clk), .rst(rst), .mode_wr(wr_mode), .mode_new(mode_new),
    .mode_cur(mode_q), .match(match), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      gr_q     <= '0;
      cmp_evt  <= 1'b0;
      cap_flag <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= mode_new;
      // software write wins over a capture in the same cycle
      if (wr_gr)     gr_q <= wdata;
      else if (trig) gr_q <= cnt_in;
      cap_flag <= trig && !wr_gr;
      cmp_evt  <= match && !is_capture(mode_q);
    end
  end
endmodule

// File: rtl/tmr_cc_chan_chk.sv
module tmr_cc_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_mode,
  input logic             wr_gr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] cnt_in,
  input logic [3:0]       mode_q,
  input logic [CNT_W-1:0] gr_q,
  input logic             pin_out,
  input logic             pin_oe,
  input logic             cap_flag
);
  assert_oe_capture_R4: assert property (@(posedge clk) disable iff (rst)
    mode_q[3] |-> !pin_oe);

  assert_oe_action_R4: assert property (@(posedge clk) disable iff (rst)
    pin_oe |-> (!mode_q[3] && mode_q[1:0] != 2'b00));

  assert_init_level_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_mode) && !$past(wdata[3])) |-> pin_out == $past(wdata[2]));

  assert_match_high_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_mode) && !$past(mode_q[3]) && $past(mode_q[1:0]) == 2'b10
     && $past(cnt_in) == $past(gr_q)) |-> pin_out);

  assert_match_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_mode) && !$past(mode_q[3]) && $past(mode_q[1:0]) == 2'b11
     && $past(cnt_in) == $past(gr_q)) |-> pin_out != $past(pin_out));

  assert_cap_value_R9: assert property (@(posedge clk) disable iff (rst)
    cap_flag |-> gr_q == $past(cnt_in));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_gr)) |-> (!cap_flag && gr_q == $past(wdata)));
endmodule

bind tmr_cc_chan tmr_cc_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_mode(wr_mode), .wr_gr(wr_gr), .wdata(wdata),
  .cnt_in(cnt_in), .mode_q(mode_q), .gr_q(gr_q), .pin_out(pin_out),
  .pin_oe(pin_oe), .cap_flag(cap_flag)
);

// File: tb/sim_tmr_cc_chan.sv
module sim_tmr_cc_chan;
  localparam int CNT_W = 16;
  localparam logic [15:0] IDLE = 16'h7777;

  logic clk = 1'b0, rst = 1'b1, wr_mode = 1'b0, wr_gr = 1'b0, pin_in = 1'b0, evt_in = 1'b0;
  logic [CNT_W-1:0] wdata = '0, cnt_in = IDLE;
  logic [3:0] mode_q;
  logic [CNT_W-1:0] gr_q;
  logic pin_out, pin_oe, cmp_evt, cap_flag;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  tmr_cc_chan #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .wr_mode(wr_mode), .wr_gr(wr_gr), .wdata(wdata),
    .cnt_in(cnt_in), .pin_in(pin_in), .evt_in(evt_in), .mode_q(mode_q),
    .gr_q(gr_q), .pin_out(pin_out), .pin_oe(pin_oe), .cmp_evt(cmp_evt),
    .cap_flag(cap_flag)
  );

  // {mode, gr, cnt, exp_pin_after_match, exp_oe}
  localparam int NV = 9;
  localparam logic [37:0] VEC [NV] = '{
    {4'b0001, 16'd100, 16'd100, 1'b0, 1'b1},
    {4'b0101, 16'd100, 16'd100, 1'b0, 1'b1},
    {4'b0010, 16'd100, 16'd100, 1'b1, 1'b1},
    {4'b0110, 16'd100, 16'd100, 1'b1, 1'b1},
    {4'b0011, 16'd100, 16'd100, 1'b1, 1'b1},
    {4'b0111, 16'd100, 16'd100, 1'b0, 1'b1},
    {4'b0000, 16'd100, 16'd100, 1'b0, 1'b0},
    {4'b0100, 16'd100, 16'd100, 1'b1, 1'b0},
    {4'b0011, 16'd200, 16'd199, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    wr_mode = 1'b1; wdata = {12'h0, m};
    tick(1);
    wr_mode = 1'b0;
  endtask

  task automatic set_gr(input logic [15:0] v);
    wr_gr = 1'b1; wdata = v;
    tick(1);
    wr_gr = 1'b0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        summary();
      end
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1 mode", mode_q, 0);
    check("R1 gr", gr_q, 0);
    check("R1 pin/oe/flags", {pin_out, pin_oe, cap_flag}, 0);

    // compare-mode vector table: R2 R3 R4 R5 R11
    for (int v = 0; v < NV; v++) begin
      logic [3:0] m; logic [15:0] g, c; logic ep, eo;
      {m, g, c, ep, eo} = VEC[v];
      set_mode(m);
      set_gr(g);
      check("R11 gr write", gr_q, g);
      check("R2 initial level", pin_out, m[2]);
      check("R4 oe", pin_oe, eo);
      cnt_in = c;
      tick(1);
      cnt_in = IDLE;
      check("R3 match action", pin_out, ep);
      check("R5 match strobe", cmp_evt, (g == c));
      tick(1);
      check("R5 strobe one cycle", cmp_evt, 0);
    end

    // R3 toggle on consecutive matches
    set_mode(4'b0011);
    set_gr(16'h0042);
    cnt_in = 16'h0042;
    tick(1);
    check("R3 toggle 1", pin_out, 1);
    tick(1);
    check("R3 toggle 2", pin_out, 0);
    cnt_in = IDLE;

    // capture on rising edge: R6 R7 R9 R4
    set_mode(4'b1000);
    check("R4 oe off in capture", pin_oe, 0);
    cnt_in = 16'h1234;
    pin_in = 1'b1;
    tick(2);
    check("R6 not yet captured", cap_flag, 0);
    tick(1);
    check("R6 R9 capture flag", cap_flag, 1);
    check("R7 rising capture value", gr_q, 16'h1234);
    tick(1);
    check("R9 flag one cycle", cap_flag, 0);
    cnt_in = 16'h2222;
    pin_in = 1'b0;
    tick(4);
    check("R7 falling ignored in rising mode", gr_q, 16'h1234);

    // falling mode
    pin_in = 1'b1;
    tick(4);
    set_mode(4'b1001);
    cnt_in = 16'h3333;
    pin_in = 1'b0;
    tick(3);
    check("R7 falling capture", gr_q, 16'h3333);
    cnt_in = 16'h3434;
    pin_in = 1'b1;
    tick(4);
    check("R7 rising ignored in falling mode", gr_q, 16'h3333);

    // both edges
    set_mode(4'b1010);
    cnt_in = 16'h4444;
    pin_in = 1'b0;
    tick(3);
    check("R7 both: fall", gr_q, 16'h4444);
    cnt_in = 16'h5555;
    pin_in = 1'b1;
    tick(3);
    check("R7 both: rise", gr_q, 16'h5555);

    // cross-channel event: R8
    set_mode(4'b1100);
    cnt_in = 16'h6666;
    pin_in = 1'b0;
    tick(4);
    check("R8 pin ignored", {cap_flag, gr_q}, {1'b0, 16'h5555});
    evt_in = 1'b1;
    tick(1);
    evt_in = 1'b0;
    check("R8 event capture", {cap_flag, gr_q}, {1'b1, 16'h6666});
    tick(1);
    check("R9 event flag one cycle", cap_flag, 0);

    // R10 write beats capture
    cnt_in = 16'h1111;
    evt_in = 1'b1; wr_gr = 1'b1; wdata = 16'hBEEF;
    tick(1);
    evt_in = 1'b0; wr_gr = 1'b0;
    check("R10 write wins", {cap_flag, gr_q}, {1'b0, 16'hBEEF});

    // R1 reset mid-run
    set_mode(4'b0110);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    check("R1 reset again", {mode_q, gr_q, pin_out, pin_oe, cmp_evt, cap_flag}, 0);

    summary();
  end
endmodule